// File: doc/BRIEF.md
# Cascadable BCD Decade Counter Stage

This block holds one decimal digit and advances it through 0 to 9 on the rising clock edge. The digit wraps back to 0 after 9. A low-active synchronous load copies a four-bit value into the digit. A low-active clear forces the digit to zero as soon as it is asserted. The counter only advances when two separate high-active enables are both high.

The first enable, `en_count`, gates the stage locally. The second, `en_chain`, carries the chained qualification and also gates the wrap output. `wrap_out` is high while the digit reads 9 and `en_chain` is high. It is formed combinationally, so it can drive `en_chain` of the next stage directly. With `en_count` of every later stage tied high, a row of stages counts as one multi-digit decimal counter.

The stage also recovers from the six codes that are not BCD digits. Each of them returns to the legal range within two enabled clocks. The release of the clear passes through a short synchroniser, so the first edge that loads or counts after a clear is always clean.

Top module: `bcd_decade_stage`

## Requirements
- R1: While `clear_n` is low, `digit` reads 0 and `wrap_out` reads 0 at once, without waiting for a clock edge and whatever `load_n`, `en_count`, `en_chain` and `load_val` are doing.
- R2: After `clear_n` rises, the first two rising edges leave `digit` at 0 even if a load or a count is requested. The third rising edge is the first one that can load or count.
- R3: With `load_n` low, a rising edge copies `load_val` into `digit`, whatever the levels of `en_count` and `en_chain`.
- R4: With `load_n` high, `digit` keeps its value across an edge unless both `en_count` and `en_chain` are high.
- R5: With `load_n` high and both enables high, `digit` steps 0,1,...,8,9 and then goes to 0.
- R6: `wrap_out` is 1 exactly when `digit` equals 9 and `en_chain` is 1. It follows a change of `en_chain` within the same cycle, and `en_count` has no effect on it.
- R7: A counting edge takes the codes 10, 12 and 14 up by one, and takes the codes 11, 13 and 15 to 0. None of the codes 10 to 15 ever raises `wrap_out`.
- R8: Three stages, each one's `en_chain` fed by the previous stage's `wrap_out` and each later `en_count` tied high, count as one decimal value modulo 1000. Each later digit advances exactly once per wrap of the digit before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Clear, low-active, asserts asynchronously and is released through a synchroniser |
| load_n | input | 1 | Synchronous load, low-active, takes priority over counting |
| en_count | input | 1 | Local count enable, high-active |
| en_chain | input | 1 | Chained count enable, high-active, also qualifies `wrap_out` |
| load_val | input | 4 | Value copied into the digit on a load |
| digit | output | 4 | Current counter value |
| wrap_out | output | 1 | High while the digit is 9 and `en_chain` is high |

## Verification
The hardest case to reach from the ports is a carry that ripples through the whole chain, where all three digits read 9 and a single count returns them to 000. In free-running count this takes hundreds of cycles. The stimulus gets there directly by loading 9, 9, 9 and 9, 9, 8. It then runs a long seeded random stretch with sparse loads and clears, in which the bench compares the three digits against a modulo-1000 reference. Illegal codes can only enter through a load, so each of them is loaded in turn and then stepped.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

  localparam int unsigned DIGIT_W   = 4;
  localparam int unsigned SYNC_LEN  = 2;

  typedef logic [DIGIT_W-1:0] digit_t;

  localparam digit_t DIGIT_LAST = digit_t'(9);

  // One counting step. The codes with bit 3 and bit 0 both set (9, 11,
  // 13, 15) go to zero; every other code goes up by one.
  function automatic digit_t bcd_step(input digit_t v);
    if (v[3] && v[0]) return '0;
    return v + digit_t'(1);
  endfunction

  function automatic logic bcd_at_last(input digit_t v);
    return v == DIGIT_LAST;
  endfunction

  function automatic logic bcd_illegal(input digit_t v);
    return v > DIGIT_LAST;
  endfunction

endpackage

// File: rtl/bcd_release_sync.sv
module bcd_release_sync #(
  parameter int unsigned STAGES = bcd_pkg::SYNC_LEN
) (
  input  logic clk,
  input  logic clear_n,
  output logic rst_n
);

  logic [STAGES-1:0] shift_q;

  // Goes low at once with clear_n, comes back high only after STAGES edges.
  always_ff @(posedge clk or negedge clear_n) begin
    if (!clear_n) shift_q <= '0;
    else          shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = shift_q[STAGES-1];

endmodule

// File: rtl/bcd_digit_register.sv
module bcd_digit_register
  import bcd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load_n,
  input  logic   step_en,
  input  digit_t load_val,
  output digit_t q
);

  logic   take_load;
  logic   take_step;
  digit_t next_q;

  // Load wins over counting; counting needs the combined enable.
  assign take_load = !load_n;
  assign take_step = load_n && step_en;

  always_comb begin
    next_q = q;
    if (take_load)      next_q = load_val;
    else if (take_step) next_q = bcd_step(q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= next_q;
  end

  AST_RELEASE_HOLD: assert property (@(posedge clk)
    !rst_n |=> q == '0);  // R2

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    take_load |=> q == $past(load_val));  // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !step_en) |=> $stable(q));  // R4

  AST_WRAP_NINE: assert property (@(posedge clk) disable iff (!rst_n)
    (take_step && q == 4'd9) |=> q == '0);  // R5

  AST_ILLEGAL_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (take_step && q > 4'd9) |=> (q == '0 || q[0]));  // R7

endmodule

// File: rtl/bcd_terminal_decode.sv
module bcd_terminal_decode
  import bcd_pkg::*;
(
  input  digit_t q,
  input  logic   chain_en,
  output logic   at_last,
  output logic   wrap
);

  assign at_last = bcd_at_last(q);
  assign wrap    = chain_en && at_last;

  always_comb begin
    if (bcd_illegal(q)) AST_NO_ILLEGAL_WRAP: assert (!wrap);  // R7
  end

endmodule

// File: rtl/bcd_decade_stage.sv
module bcd_decade_stage
  import bcd_pkg::*;
(
  input  logic       clk,
  input  logic       clear_n,
  input  logic       load_n,
  input  logic       en_count,
  input  logic       en_chain,
  input  logic [3:0] load_val,
  output logic [3:0] digit,
  output logic       wrap_out
);

  logic   rst_sync_n;
  logic   step_en;
  logic   at_last;
  digit_t q_int;

  assign step_en = en_count && en_chain;

  bcd_release_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk     (clk),
    .clear_n (clear_n),
    .rst_n   (rst_sync_n)
  );

  bcd_digit_register u_reg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_n   (load_n),
    .step_en  (step_en),
    .load_val (load_val),
    .q        (q_int)
  );

  bcd_terminal_decode u_term (
    .q        (q_int),
    .chain_en (en_chain),
    .at_last  (at_last),
    .wrap     (wrap_out)
  );

  assign digit = q_int;

  AST_CLEAR_ZERO: assert property (@(posedge clk)
    !clear_n |-> (digit == 4'd0 && !wrap_out));  // R1

  AST_TC_TERMINAL: assert property (@(posedge clk) disable iff (!clear_n)
    wrap_out |-> (digit == 4'd9 && en_chain && at_last));  // R6

endmodule

// File: tb/bcd_decade_stage_bench.sv
`timescale 1ns/1ps
module bcd_decade_stage_bench;

  logic       clk = 1'b0;
  logic       clear_n = 1'b0;
  logic       load_n = 1'b1;
  logic       en_count0 = 1'b0;
  logic       en_chain0 = 1'b0;
  logic [3:0] dv [3];
  logic [3:0] q0, q1, q2;
  logic       tc0, tc1, tc2;

  int checks = 0;
  int fails  = 0;
  int m [3];
  int hold = 0;
  int ref_val = 0;
  bit ref_ok = 1'b1;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bcd_decade_stage u_bcd_decade_stage (
    .clk(clk), .clear_n(clear_n), .load_n(load_n), .en_count(en_count0),
    .en_chain(en_chain0), .load_val(dv[0]), .digit(q0), .wrap_out(tc0));

  bcd_decade_stage u_bcd_decade_stage_d1 (
    .clk(clk), .clear_n(clear_n), .load_n(load_n), .en_count(1'b1),
    .en_chain(tc0), .load_val(dv[1]), .digit(q1), .wrap_out(tc1));

  bcd_decade_stage u_bcd_decade_stage_d2 (
    .clk(clk), .clear_n(clear_n), .load_n(load_n), .en_count(1'b1),
    .en_chain(tc1), .load_val(dv[2]), .digit(q2), .wrap_out(tc2));

  function automatic int ref_next(input int v);
    case (v)
      9, 11, 13, 15: return 0;
      default:       return v + 1;
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string req);
    bit e0, e1, e2;
    e0 = (m[0] == 9) && en_chain0;
    e1 = (m[1] == 9) && e0;
    e2 = (m[2] == 9) && e1;
    check(req, "digit0", int'(q0), m[0]);
    check(req, "digit1", int'(q1), m[1]);
    check(req, "digit2", int'(q2), m[2]);
    check("R6", "wrap0", int'(tc0), int'(e0));
    check("R6", "wrap1", int'(tc1), int'(e1));
    check("R6", "wrap2", int'(tc2), int'(e2));
    if (ref_ok)
      check("R8", "value", 100*int'(q2) + 10*int'(q1) + int'(q0), ref_val);
  endtask

  // Advances the model at the edge, checks 1 ns later, returns at the negedge.
  task automatic tick(input string req);
    bit t0, t1, c0;
    @(posedge clk);
    if (!clear_n) begin
      m[0] = 0; m[1] = 0; m[2] = 0; hold = 0; ref_val = 0; ref_ok = 1'b1;
    end else if (hold < 2) begin
      hold++;
    end else if (!load_n) begin
      for (int i = 0; i < 3; i++) m[i] = int'(dv[i]);
      ref_ok  = (m[0] < 10) && (m[1] < 10) && (m[2] < 10);
      ref_val = m[2]*100 + m[1]*10 + m[0];
    end else begin
      t0 = (m[0] == 9) && en_chain0;
      t1 = (m[1] == 9) && t0;
      c0 = en_count0 && en_chain0;
      if (t0 && !c0) ref_ok = 1'b0;
      if (c0) begin
        m[0] = ref_next(m[0]);
        ref_val = (ref_val + 1) % 1000;
      end
      if (t0) m[1] = ref_next(m[1]);
      if (t1) m[2] = ref_next(m[2]);
    end
    #1;
    compare_all(req);
    @(negedge clk);
  endtask

  task automatic set_d(input int a, input int b, input int c);
    dv[0] = 4'(a); dv[1] = 4'(b); dv[2] = 4'(c);
  endtask

  initial begin
    set_d(0, 0, 0);
    void'($urandom(32'd1990));
    // R1: reset state
    repeat (2) tick("R1");
    check("R1", "reset wrap0", int'(tc0), 0);

    // R2: release, then two held edges despite load and count requests
    clear_n = 1'b1; load_n = 1'b0; en_count0 = 1'b1; en_chain0 = 1'b1;
    set_d(5, 5, 5);
    tick("R2");
    tick("R2");
    tick("R3");
    check("R3", "loaded 555", int'(q0), 5);

    // R3: load with both enables low
    en_count0 = 1'b0; en_chain0 = 1'b0; set_d(3, 7, 2);
    tick("R3");

    // R4: hold with one enable low at a time
    load_n = 1'b1; en_count0 = 1'b0; en_chain0 = 1'b1;
    repeat (3) tick("R4");
    en_count0 = 1'b1; en_chain0 = 1'b0;
    repeat (3) tick("R4");

    // R5: full decade sequence from zero
    load_n = 1'b0; set_d(0, 0, 0); tick("R3");
    load_n = 1'b1; en_count0 = 1'b1; en_chain0 = 1'b1;
    repeat (25) tick("R5");

    // R6: wrap_out follows en_chain within the cycle, ignores en_count
    load_n = 1'b0; set_d(9, 0, 0); tick("R3");
    load_n = 1'b1; en_count0 = 1'b0; en_chain0 = 1'b1;
    #0.5;
    check("R6", "wrap0 at 9", int'(tc0), 1);
    en_count0 = 1'b1; #0.5;
    check("R6", "wrap0 en_count high", int'(tc0), 1);
    en_chain0 = 1'b0; #0.5;
    check("R6", "wrap0 chain dropped", int'(tc0), 0);
    en_count0 = 1'b0; #0.5;
    check("R6", "wrap0 en_count low", int'(tc0), 0);
    @(negedge clk);
    tick("R6");

    // R7: each illegal code, two counting edges
    for (int v = 10; v < 16; v++) begin
      load_n = 1'b0; set_d(v, 0, 0); en_count0 = 1'b1; en_chain0 = 1'b1;
      tick("R7");
      check("R7", "illegal no wrap", int'(tc0), 0);
      load_n = 1'b1;
      tick("R7");
      tick("R7");
      check("R7", "back in range", int'(q0 < 4'd10), 1);
    end

    // R8: full ripple 999 -> 000 and 998 -> 999 -> 000
    load_n = 1'b0; set_d(9, 9, 9); tick("R3");
    load_n = 1'b1; en_count0 = 1'b1; en_chain0 = 1'b1;
    check("R8", "wrap2 at 999", int'(tc2), 1);
    tick("R8");
    check("R8", "digit2 after 999", int'(q2), 0);
    load_n = 1'b0; set_d(8, 9, 9); tick("R3");
    load_n = 1'b1;
    repeat (3) tick("R8");

    // R1: clear asserted mid-cycle with a load pending
    #1; clear_n = 1'b0; load_n = 1'b0; set_d(7, 7, 7); #0.5;
    check("R1", "async digit0", int'(q0), 0);
    check("R1", "async digit2", int'(q2), 0);
    check("R1", "async wrap0", int'(tc0), 0);
    @(negedge clk);
    tick("R1");
    clear_n = 1'b1;
    tick("R2"); tick("R2"); tick("R3");

    // Random stretch
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom_range(999, 0));
      load_n    = !(r < 15);
      clear_n   = !(r >= 995);
      en_count0 = ($urandom_range(9, 0) < 8);
      en_chain0 = ($urandom_range(9, 0) < 9);
      if (r < 3) set_d(int'($urandom_range(15, 0)), int'($urandom_range(9, 0)), int'($urandom_range(9, 0)));
      else set_d(int'($urandom_range(9, 0)), int'($urandom_range(9, 0)), int'($urandom_range(9, 0)));
      tick("R8");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule